// File: doc/BRIEF.md
# Prioritised 32-Source Interrupt Controller

This block gathers up to 32 asynchronous interrupt request lines behind one 32-bit register port. Each line first passes through a two-flop synchronizer. Each line can then be configured for level or edge detection and for either active sense. A detected request sets a sticky pending bit. Software clears a pending bit by writing a one to it.

An enable mask selects which pending bits reach the outputs. A routing register sends each enabled source either to a normal interrupt line or to a critical interrupt line. A vector register reports the lowest-numbered source that is pending and enabled, which is the source with the highest priority. Three source numbers are reserved and stay inert.

All registers use the same bit order. Source `n` lives in bit `31-n`, so source 0 is the most significant bit. The request pins use this order too.

Top module: `prio_irq_hub`

## Requirements
- R1: Source n (0..31) occupies bit 31-n of `src_in` and of every register, so source 0 is bit 31.
- R2: Sources 17, 18 and 19 (mask 0x00007000) are reserved. Their pending bits never set, writes to them have no effect, and every register reads 0 in those bits.
- R3: Requests pass a two-flop synchronizer. A level request driven before clock edge k shows as pending after edge k+2, and not after edge k+1.
- R4: In level mode, a pending bit is set again on every cycle the synchronized input is active. A write-1 clear therefore only sticks once the input has gone inactive.
- R5: In edge mode (trigger bit 1), a pending bit sets once, on the transition into the active sense. A clear written while the input stays active then holds.
- R6: Writing 1 to a bit at offset 0x00 clears that pending bit, and writing 0 leaves it unchanged. When a set and a clear meet in the same cycle, the set wins.
- R7: In the sense register, 0 selects active-low or falling and 1 selects active-high or rising. At reset, trigger, sense, enable and pending are all 0, and the routing register resets to 1 in every non-reserved bit.
- R8: Offset 0x14 reads pending AND enable.
- R9: A routing bit of 1 sends the source to `irq_norm`, and 0 sends it to `irq_crit`. Each output is high while any enabled pending source routed to it exists.
- R10: Offset 0x18 reads the number of the lowest-numbered enabled pending source, or 0xFFFFFFFF when there is none.
- R11: The register offsets are: pending 0x00, enable 0x04, routing 0x08, sense 0x0C, trigger 0x10, masked 0x14, vector 0x18. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Raw request lines, source n on bit 31-n |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical interrupt request |

## Verification
The bench checks the exact latency through the synchronizer. A design with one flop too few or too many would show the pending bit one cycle off.

It writes a clear while a level input is still asserted and expects the bit to stay set. It writes a clear while an edge input is still asserted and expects the bit to stay clear. A design that mixes up the two modes, or lets a clear beat a new set, fails one of these two checks.

Vectors with several sources pending test the priority order, where a reversed encoder would report the highest number instead of the lowest. Requests on sources 17 to 19 test the reserved slots, where a missing mask would show a pending bit or a spurious vector. A reversed routing bit would raise the wrong one of the two interrupt lines.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
  // register byte offsets
  localparam int unsigned OFS_PEND  = 32'h00;
  localparam int unsigned OFS_EN    = 32'h04;
  localparam int unsigned OFS_ROUTE = 32'h08;
  localparam int unsigned OFS_SENSE = 32'h0C;
  localparam int unsigned OFS_TRIG  = 32'h10;
  localparam int unsigned OFS_MASKD = 32'h14;
  localparam int unsigned OFS_VEC   = 32'h18;
  // reserved sources 17..19 at bits 14..12
  localparam logic [31:0] RSVD_DEFAULT = 32'h0000_7000;
endpackage

// File: rtl/irqh_sync.sv
module irqh_sync #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        sync_q <= RST_VAL[b];
      end else begin
        meta_q <= d[b];
        sync_q <= meta_q;
      end
    end
    assign q[b] = sync_q;
  end
endmodule

// File: rtl/irqh_detect.sv
module irqh_detect #(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] RSVD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_now,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] sense,
  output logic [N-1:0] set_evt
);
  logic [N-1:0] prev_q;
  logic [N-1:0] active_w, level_evt, edge_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl_now;
  end

  assign active_w  = ~(lvl_now ^ sense);
  assign level_evt = ~trig & active_w;
  assign edge_evt  = trig & active_w & (lvl_now ^ prev_q);
  assign set_evt   = (level_evt | edge_evt) & ~RSVD;

  // R5: an edge-mode set only happens when the input changed
  assert_edge_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_evt & trig & ~(lvl_now ^ prev_q)) == '0));
endmodule

// File: rtl/irqh_prio.sv
module irqh_prio #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] msk,
  output logic [N-1:0] vec
);
  // lowest source number wins; source n sits at bit N-1-n
  function automatic logic [N-1:0] pick_src(input logic [N-1:0] m);
    logic [N-1:0] r;
    r = '1;
    for (int n = N - 1; n >= 0; n--) begin
      if (m[N-1-n]) r = N'(n);
    end
    return r;
  endfunction

  assign vec = pick_src(msk);
endmodule

// File: rtl/prio_irq_hub.sv
module prio_irq_hub #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [N_SRC-1:0] RSVD = N_SRC'(irqh_pkg::RSVD_DEFAULT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_SRC-1:0]  wdata,
  output logic [N_SRC-1:0]  rdata,
  output logic              irq_norm,
  output logic              irq_crit
);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(irqh_pkg::OFS_PEND);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(irqh_pkg::OFS_EN);
  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(irqh_pkg::OFS_ROUTE);
  localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(irqh_pkg::OFS_SENSE);
  localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(irqh_pkg::OFS_TRIG);
  localparam logic [ADDR_W-1:0] A_MASKD = ADDR_W'(irqh_pkg::OFS_MASKD);
  localparam logic [ADDR_W-1:0] A_VEC   = ADDR_W'(irqh_pkg::OFS_VEC);
  localparam logic [N_SRC-1:0]  LIVE    = ~RSVD;

  logic [N_SRC-1:0] pend_q, en_q, route_q, sense_q, trig_q;
  logic [N_SRC-1:0] lvl_sync, set_evt, clr_vec, msk_w, vec_w, wmask;
  logic             wr_pend;

  irqh_sync #(.W(N_SRC), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_in), .q(lvl_sync));

  irqh_detect #(.N(N_SRC), .RSVD(RSVD)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl_now(lvl_sync),
    .trig(trig_q), .sense(sense_q), .set_evt(set_evt));

  assign wr_pend = wr_en && (addr == A_PEND);
  assign wmask   = wdata & LIVE;
  assign clr_vec = wr_pend ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      en_q    <= '0;
      route_q <= LIVE;
      sense_q <= '0;
      trig_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | set_evt;
      if (wr_en) begin
        case (addr)
          A_EN:    en_q    <= wmask;
          A_ROUTE: route_q <= wmask;
          A_SENSE: sense_q <= wmask;
          A_TRIG:  trig_q  <= wmask;
          default: ;
        endcase
      end
    end
  end

  assign msk_w = pend_q & en_q;

  irqh_prio #(.N(N_SRC)) u_prio (.msk(msk_w), .vec(vec_w));

  assign irq_norm = |(msk_w & route_q);
  assign irq_crit = |(msk_w & ~route_q);

  always_comb begin
    case (addr)
      A_PEND:  rdata = pend_q;
      A_EN:    rdata = en_q;
      A_ROUTE: rdata = route_q;
      A_SENSE: rdata = sense_q;
      A_TRIG:  rdata = trig_q;
      A_MASKD: rdata = msk_w;
      A_VEC:   rdata = vec_w;
      default: rdata = '0;
    endcase
  end

  // R2: reserved pending bits stay low
  assert_rsvd_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & RSVD) == '0));
  // R6: a written one clears the bit unless a new set arrives
  assert_w1c_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && ((wmask & ~set_evt) != '0)) |=>
    ((pend_q & $past(wmask & ~set_evt)) == '0));
  // R6: pending bits only fall through a clear write
  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_pend) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // R10: an output is up exactly when the vector names a source
  assert_vec_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_norm || irq_crit) == (vec_w != '1)));
endmodule

// File: tb/sim_prio_irq_hub.sv
module sim_prio_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = 32'hFFFF_FFFF;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_norm, irq_crit;
  int total = 0;
  int bad = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  prio_irq_hub u0 (.clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_norm(irq_norm), .irq_crit(irq_crit));

  // entry: sense, enable, route, src, exp_vec, exp_norm, exp_crit  (level mode)
  localparam int NT = 8;
  localparam logic [161:0] TBL [NT] = '{
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h80000000, 32'd0,        1'b1, 1'b0},
    {32'h00000000, 32'hFFFFFFFF, 32'h00000000, 32'hFBFFFFFF, 32'd5,        1'b0, 1'b1},
    {32'hFFFFFFFF, 32'h00000001, 32'h00000001, 32'h00010003, 32'd31,       1'b1, 1'b0},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b0},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00F00000, 32'h00F00000, 32'd8,        1'b1, 1'b0},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00007000, 32'hFFFFFFFF, 1'b0, 1'b0},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00007800, 32'd20,       1'b0, 1'b1},
    {32'hFFFFFFFF, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'h00000003, 32'd30,       1'b1, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3); rst_n = 1'b1; step(2);
    // reset state (R7, R10)
    rd(8'h00, rv); chk("R7 pending reset", rv, 32'h0);
    rd(8'h08, rv); chk("R7 route reset", rv, 32'hFFFF8FFF);
    rd(8'h0C, rv); chk("R7 sense reset", rv, 32'h0);
    rd(8'h10, rv); chk("R7 trigger reset", rv, 32'h0);
    rd(8'h18, rv); chk("R10 vector idle", rv, 32'hFFFFFFFF);
    chk("R9 outputs idle", {30'h0, irq_norm, irq_crit}, 32'h0);
    // reserved write and unused offset (R2, R11)
    wr(8'h04, 32'hFFFFFFFF);
    rd(8'h04, rv); chk("R2 enable reserved bits", rv, 32'hFFFF8FFF);
    rd(8'h1C, rv); chk("R11 unused offset", rv, 32'h0);

    // table walk, level mode (R1, R2, R7, R9, R10)
    for (int i = 0; i < NT; i++) begin
      logic [31:0] sn, en, ro, sr, ev;
      logic en_n, en_c;
      {sn, en, ro, sr, ev, en_n, en_c} = TBL[i];
      src_in = ~sn;
      wr(8'h0C, sn); wr(8'h04, en); wr(8'h08, ro); wr(8'h10, 32'h0);
      step(3);
      wr(8'h00, 32'hFFFFFFFF);
      src_in = sr;
      step(3);
      rd(8'h18, rv); chk($sformatf("R10 vector entry %0d", i), rv, ev);
      chk($sformatf("R9 outputs entry %0d", i), {30'h0, irq_norm, irq_crit}, {30'h0, en_n, en_c});
      src_in = ~sn; step(3);
      wr(8'h00, 32'hFFFFFFFF);
    end

    // level mode, latency and blocked clear (R3, R4, R8, R6)
    src_in = 32'h0; wr(8'h0C, 32'hFFFFFFFF); wr(8'h04, 32'h01000000); step(3);
    wr(8'h00, 32'hFFFFFFFF);
    src_in = 32'h01000000;      // source 7
    step(2);
    rd(8'h00, rv); chk("R3 not yet pending", rv, 32'h0);
    step(1);
    rd(8'h00, rv); chk("R3 pending after sync", rv, 32'h01000000);
    wr(8'h00, 32'h0);
    rd(8'h00, rv); chk("R6 write zero keeps", rv, 32'h01000000);
    rd(8'h14, rv); chk("R8 masked view", rv, 32'h01000000);
    wr(8'h00, 32'h01000000);
    rd(8'h00, rv); chk("R4 clear blocked while active", rv, 32'h01000000);
    src_in = 32'h0; step(3);
    wr(8'h00, 32'h01000000);
    rd(8'h00, rv); chk("R4 clear after release", rv, 32'h0);

    // edge mode rising then falling (R5, R7)
    wr(8'h10, 32'h10000000);    // source 3 edge
    src_in = 32'h10000000; step(3);
    rd(8'h00, rv); chk("R5 rising edge sets", rv, 32'h10000000);
    wr(8'h00, 32'h10000000); step(2);
    rd(8'h00, rv); chk("R5 clear holds while high", rv, 32'h0);
    wr(8'h0C, 32'hEFFFFFFF); step(2);
    rd(8'h00, rv); chk("R7 no set on sense change", rv, 32'h0);
    src_in = 32'h0; step(3);
    rd(8'h00, rv); chk("R7 falling edge sets", rv, 32'h10000000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule